// File: doc/BRIEF.md
# Supply-Monitor Power-On Reset Sequencer

This block turns a digital supply-good level, produced by an external voltage comparator, into an active-low system reset. At power-up the reset stays asserted while the supply is bad. Once the supply is good it stays asserted for a programmable power-on delay. That delay equals one watchdog period and is shared with the downstream watchdog. When the supply recovers after a drop, the full delay starts again, so a supply that drops out and returns cannot make reset chatter.

A supply drop acts only after it has persisted for a programmable number of clock cycles. Once it has, reset is asserted at once and overrides everything else. Two plain status outputs drive the downstream watchdog. The first is a one-cycle strobe at the moment reset is released. The second is an abort level that is high whenever reset is held. While the abort level is high, the watchdog ignores clear pulses and forces its enable output inactive.

The supply-good input is asynchronous and passes through a synchronizer. A synchronous active-high `rst` returns the block to its power-up state. All pins are plain control and status levels. There is no streaming interface, so no valid/ready or back-pressure rules apply.

Top module: `por_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `sys_rst_n` is 0, `por_done` is 0 and `wd_abort` is 1.
- R2: While the supply-good input has not been high long enough, `sys_rst_n` stays 0. This holds both after power-up and after a qualified drop.
- R3: If `supply_ok` is sampled high at clock edge n and at every edge after it, `sys_rst_n` is 0 after edge n+TWD_CYC+2 and is 1 after edge n+TWD_CYC+3. The three extra cycles are the input latency.
- R4: If `supply_ok` is sampled low at FILT_CYC or more consecutive edges, the first of them being edge n, `sys_rst_n` becomes 0 after edge n+FILT_CYC+2. It is also 0 after every later edge until the delay completes again.
- R5: A low run of fewer than FILT_CYC consecutive samples, with the reset already released, leaves `sys_rst_n` at 1 and does not raise `por_done`.
- R6: After a qualified drop, including one that occurs while the delay is running, the next release waits a full TWD_CYC+3 cycles, counted from the first high sample after the drop.
- R7: `por_done` is 1 for exactly the one cycle in which `sys_rst_n` goes from 0 to 1, and is 0 at all other times.
- R8: `wd_abort` is always the inverse of `sys_rst_n`. It is high while the supply is bad or the delay is running.
- R9: A low run shorter than FILT_CYC that occurs during the delay neither restarts nor lengthens it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to the power-up state |
| supply_ok | input | 1 | Asynchronous supply-good level from the comparator (1 = good) |
| sys_rst_n | output | 1 | Active-low system reset |
| por_done | output | 1 | One-cycle strobe when reset is released |
| wd_abort | output | 1 | High while reset is held; tells the watchdog to abort and to force its enable inactive |

## Verification
The bench targets four corner cases:
- A low run of exactly FILT_CYC-1 samples must be ignored, and a run of exactly FILT_CYC must act. A filter that is off by one would either reset on a glitch or miss a genuine drop.
- A drop during the delay must restart the whole count from the next good sample. A design that only paused the count would release reset early.
- A glitch during the delay must not restart the count. A design that restarted here would release reset late.
- The release cycle and the single `por_done` strobe are checked against the exact TWD_CYC+3 latency. Miscounted pipeline stages would shift them by a cycle, and a sticky strobe would stay high.

// File: rtl/por_pkg.sv
package por_pkg;
  typedef enum logic [1:0] {
    ST_DOWN  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RUN   = 2'd2
  } por_state_e;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/por_drop_filter.sv
module por_drop_filter #(
  parameter int unsigned FILT_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ok_sync,
  output logic good
);
  localparam int unsigned CW = por_pkg::cnt_w(FILT_CYC);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      good    <= 1'b0;
      low_cnt <= '0;
    end else if (ok_sync) begin
      good    <= 1'b1;
      low_cnt <= '0;
    end else if (good) begin
      if (low_cnt == LAST) begin
        good    <= 1'b0;
        low_cnt <= '0;
      end else begin
        low_cnt <= low_cnt + 1'b1;
      end
    end else begin
      low_cnt <= '0;
    end
  end

  // The low-run counter never reaches the filter length.
  assert_lowcnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    low_cnt <= LAST);

  // A good synchronized sample always leaves the filter good.
  assert_recover_R6: assert property (@(posedge clk) disable iff (rst)
    ok_sync |=> good);
endmodule

// File: rtl/por_delay_ctrl.sv
module por_delay_ctrl
  import por_pkg::*;
#(
  parameter int unsigned TWD_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic good,
  output logic sys_rst_n,
  output logic por_done,
  output logic wd_abort
);
  localparam int unsigned CW = cnt_w(TWD_CYC);
  localparam logic [CW-1:0] LAST = CW'(TWD_CYC - 1);

  por_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!good) begin
      state_d = ST_DOWN;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_DOWN: begin
          state_d = ST_DELAY;
          cnt_d   = '0;
        end
        ST_DELAY: begin
          if (cnt_q == LAST) begin
            state_d = ST_RUN;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_RUN:  state_d = ST_RUN;
        default: state_d = ST_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_DOWN;
      cnt_q     <= '0;
      sys_rst_n <= 1'b0;
      wd_abort  <= 1'b1;
      por_done  <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      sys_rst_n <= (state_d == ST_RUN);
      wd_abort  <= (state_d != ST_RUN);
      por_done  <= (state_d == ST_RUN) && (state_q != ST_RUN);
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  assert_drop_forces_reset_R4: assert property (@(posedge clk) disable iff (rst)
    !good |=> (!sys_rst_n && wd_abort));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    por_done |=> !por_done);

  assert_done_on_release_R7: assert property (@(posedge clk) disable iff (rst)
    por_done |-> (sys_rst_n && !$past(sys_rst_n)));

  assert_abort_inverse_R8: assert property (@(posedge clk) disable iff (rst)
    wd_abort == !sys_rst_n);
endmodule

// File: rtl/por_sequencer.sv
module por_sequencer #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYC    = 4,
  parameter int unsigned TWD_CYC     = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  output logic sys_rst_n,
  output logic por_done,
  output logic wd_abort
);
  logic ok_sync;
  logic good;

  por_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (supply_ok),
    .q   (ok_sync)
  );

  por_drop_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk     (clk),
    .rst     (rst),
    .ok_sync (ok_sync),
    .good    (good)
  );

  por_delay_ctrl #(.TWD_CYC(TWD_CYC)) u_delay (
    .clk       (clk),
    .rst       (rst),
    .good      (good),
    .sys_rst_n (sys_rst_n),
    .por_done  (por_done),
    .wd_abort  (wd_abort)
  );

  // Power-up state while reset is held (R1).
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (!sys_rst_n && !por_done && wd_abort));
endmodule

// File: tb/test_por_sequencer.sv
module test_por_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int FILT = 4;
  localparam int TWD  = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b0;
  logic sys_rst_n, por_done, wd_abort;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";
  bit model_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  por_sequencer #(.SYNC_STAGES(2), .FILT_CYC(FILT), .TWD_CYC(TWD)) i_por_sequencer (
    .clk(clk), .rst(rst), .supply_ok(supply_ok),
    .sys_rst_n(sys_rst_n), .por_done(por_done), .wd_abort(wd_abort)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Spec model: filtered supply level per sample, length of its good run,
  // release seen three samples later.
  int low_run = 0;
  bit fg = 1'b0;
  int run_len = 0;
  int pipe [4];
  bit exp_rst_n = 1'b0;
  bit exp_done  = 1'b0;

  function automatic int next_run(input bit level, input int cur);
    if (!level) return 0;
    return (cur >= TWD + 2) ? TWD + 2 : cur + 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      low_run = 0; fg = 1'b0; run_len = 0;
      for (int i = 0; i < 4; i++) pipe[i] = 0;
    end else begin
      if (supply_ok) begin
        low_run = 0; fg = 1'b1;
      end else begin
        low_run++;
        if (low_run >= FILT) fg = 1'b0;
      end
      run_len = next_run(fg, run_len);
      for (int i = 3; i > 0; i--) pipe[i] = pipe[i-1];
      pipe[0] = run_len;
    end
    exp_rst_n = (pipe[3] >= TWD + 1);
    exp_done  = (pipe[3] == TWD + 1);
  end

  always @(negedge clk) begin
    if (model_on) begin
      check(tag, "sys_rst_n", sys_rst_n, exp_rst_n);
      check(tag, "por_done",  por_done,  exp_done);
      check("R8", "wd_abort", wd_abort,  !exp_rst_n);
    end
  end

  task automatic hold(input bit lvl, input int n);
    supply_ok = lvl;
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4242));
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "sys_rst_n in reset", sys_rst_n, 0);
    check("R1", "por_done in reset",  por_done, 0);
    check("R1", "wd_abort in reset",  wd_abort, 1);

    // R3 directed: first high sample at edge 0
    supply_ok = 1'b1; rst = 1'b0;
    repeat (TWD + 3) @(posedge clk);
    @(negedge clk);
    check("R3", "still held at n+TWD+2", sys_rst_n, 0);
    @(posedge clk); @(negedge clk);
    check("R3", "released at n+TWD+3", sys_rst_n, 1);
    check("R7", "strobe at release", por_done, 1);
    @(negedge clk);
    check("R7", "strobe one cycle", por_done, 0);
    check("R8", "abort low after release", wd_abort, 0);

    // R5 directed: glitch of FILT-1 samples ignored
    hold(1'b0, FILT - 1);
    hold(1'b1, 8);
    check("R5", "short glitch ignored", sys_rst_n, 1);

    // R4 directed: drop of exactly FILT samples; first low sample at next edge
    supply_ok = 1'b0;
    repeat (FILT + 2) @(posedge clk);
    @(negedge clk);
    check("R4", "held before filter expires", sys_rst_n, 1);
    @(posedge clk); @(negedge clk);
    check("R4", "reset at n+FILT+2", sys_rst_n, 0);
    check("R4", "abort with drop", wd_abort, 1);
    hold(1'b0, 10);
    check("R2", "low while supply bad", sys_rst_n, 0);

    // Model-checked phases
    rst = 1'b1; supply_ok = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0; model_on = 1'b1;

    tag = "R2"; hold(1'b0, 15);
    tag = "R3"; hold(1'b1, TWD + 10);
    tag = "R9"; hold(1'b0, 5); hold(1'b1, 6); hold(1'b0, FILT - 1); hold(1'b1, TWD + 8);
    tag = "R6"; hold(1'b0, FILT + 3); hold(1'b1, TWD / 2); hold(1'b0, FILT); hold(1'b1, TWD + 8);
    tag = "R4"; hold(1'b0, FILT); hold(1'b1, TWD + 8);

    for (int k = 0; k < 300; k++) begin
      int kind;
      kind = $urandom_range(0, 3);
      case (kind)
        0: begin tag = "R5"; hold(1'b0, $urandom_range(1, FILT - 1)); end
        1: begin tag = "R4"; hold(1'b0, $urandom_range(FILT, FILT + 8)); end
        2: begin tag = "R6"; hold(1'b1, $urandom_range(1, TWD)); end
        default: begin tag = "R3"; hold(1'b1, $urandom_range(TWD, 2 * TWD)); end
      endcase
    end

    tag = "R1";
    rst = 1'b1;
    @(negedge clk);
    check("R1", "sys_rst_n after mid-run reset", sys_rst_n, 0);
    check("R1", "wd_abort after mid-run reset", wd_abort, 1);
    model_on = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule